// File: doc/BRIEF.md
# BCD Calendar Clock with Read Snapshot and Staged Writes

This block keeps the time of day and the calendar as BCD byte registers: seconds, minutes, hours, date, day of week, month, two-digit year and century. A one-cycle enable, pulsed once per second by an external divider, advances the registers. Each advance is a full cascade, so a single enable can roll every field from seconds to century. The hour register has a mode bit that selects 24-hour counting or 12-hour counting with a PM flag. The date rolls over at the right length for each month, and February gets a 29th day when the year is a multiple of four.

A bus front end does not read or write the running counters directly. A snapshot strobe copies all eight registers into a read latch, and the read port serves bytes from that latch, so ticks that arrive during a long read do not tear the value. A write begins with a strobe that copies the live time into a staging buffer. Byte writes then replace entries in the buffer while the counters keep running. A commit loads the entire buffer into the counters, and an abort drops it. After reset the clock stays frozen until a commit that carries at least one written byte, which models the "time not valid" state after a total loss of power.

Top module: `bcd_rtc_shadow`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. On the tick that passes 59 the field returns to 00 and carries into the next field.
- R2: Day of week (register index 6) counts 0 to 6 and wraps to 0. It advances on every date change.
- R3: With hour bit 7 set, the hour field in bits 5:0 counts 00 to 23 in BCD. Passing 23 gives 00 with bit 7 still set, and carries a day.
- R4: With hour bit 7 clear, the hour field in bits 4:0 counts 01 to 12 and bit 5 is PM. Passing 11 gives 12 and toggles PM. Passing 12 gives 01. Going from 11 PM to 12 AM carries a day. After reset the hour register is 0x12 (12-hour mode, 12 AM).
- R5: The date rolls back to 01 after day 30 in April, June, September and November. It rolls after day 31 in the other months. In February it rolls after day 29 when the year is a multiple of 4, and after day 28 otherwise.
- R6: When the year passes 99 it becomes 00 and the century becomes 0x20. A century of 0x20 stays 0x20. After reset the century is 0x20.
- R7: A snapshot strobe copies the live time into the read latch on the next edge. rd_data is the latch byte picked by rd_sel, using the index map 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century. Later ticks leave the latch unchanged until the next strobe.
- R8: A begin strobe copies the live time into the staging buffer, and byte writes replace buffer entries while the counters keep ticking. A commit loads all eight buffer bytes, including bytes that were not written. An abort discards the buffer and leaves the live time untouched. A commit or byte write with no begin since the last commit or abort has no effect.
- R9: After reset, halted is 1 and ticks do not advance the time. A commit with no byte written leaves the block halted. The first commit that carries a written byte clears halted.
- R10: A commit in the same cycle as a tick wins: the live time equals the buffer. The following tick increments from the committed values.
- R11: One tick at 23:59:59 on 31 December of year 99 gives 00:00:00 on 1 January of year 00, with the century and the day of week advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second advance enable, one cycle wide |
| snap_req | input | 1 | Copy live time into the read latch |
| rd_sel | input | 3 | Read latch byte index |
| rd_data | output | 8 | Selected read latch byte |
| stg_begin | input | 1 | Start a staged write: copy live time into the buffer |
| stg_we | input | 1 | Write stg_wdata into buffer entry stg_sel |
| stg_sel | input | 3 | Buffer byte index |
| stg_wdata | input | 8 | Buffer write data |
| stg_commit | input | 1 | Load the buffer into the live counters |
| stg_abort | input | 1 | Discard the staged write |
| halted | output | 1 | Clock frozen until the first valid write |

## Verification
The bench sets boundary times and checks the values after one tick. It covers the end of a year in 24-hour mode, the last day of February in both a leap year and a common year, and the last day of a 30-day and of a 31-day month. A design that rolls February at a fixed length, or that compares BCD against binary limits, reaches an impossible date such as 30 February or 32 January. The three 12-hour edges are checked on their own: 11 to 12 with the PM flip, 12 to 1, and the day carry at 11 PM only. A design that carries the day on the wrong one of these edges shows it in the date byte. The staging tests let ticks run between begin and commit, so a design that loads only the written bytes, or re-copies live time at commit, shows a seconds value other than the one captured at begin. A commit that coincides with a tick must show the committed value, not that value plus one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [BYTE_W-1:0] CENT_LO = 8'h19;
    localparam logic [BYTE_W-1:0] CENT_HI = 8'h20;

    // Index 0 is the least significant byte, matching the read/write map.
    typedef struct packed {
        logic [BYTE_W-1:0] cent;   // 7
        logic [BYTE_W-1:0] wday;   // 6
        logic [BYTE_W-1:0] year;   // 5
        logic [BYTE_W-1:0] month;  // 4
        logic [BYTE_W-1:0] date;   // 3
        logic [BYTE_W-1:0] hour;   // 2
        logic [BYTE_W-1:0] min;    // 1
        logic [BYTE_W-1:0] sec;    // 0
    } rtc_time_t;

    localparam rtc_time_t RESET_TIME = '{
        cent: CENT_HI, wday: 8'h00, year: 8'h00, month: 8'h01,
        date: 8'h01, hour: 8'h12, min: 8'h00, sec: 8'h00
    };

    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
        logic [6:0] tens;
        tens = {3'b000, v[7:4]};
        return (tens << 3) + (tens << 1) + {3'b000, v[3:0]};
    endfunction

    function automatic logic is_leap(input logic [BYTE_W-1:0] yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    // Last valid date of the month, in BCD.
    function automatic logic [BYTE_W-1:0] last_day(input logic [BYTE_W-1:0] mo,
                                                  input logic [BYTE_W-1:0] yr);
        logic [BYTE_W-1:0] r;
        case (mo)
            8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);

    logic c_min, c_hr, c_day, c_mon, c_yr;
    logic [BYTE_W-1:0] h24_inc, h12, h12_inc, dim;
    logic pm;

    always_comb begin
        nxt     = cur;
        c_min   = 1'b0;
        c_hr    = 1'b0;
        c_day   = 1'b0;
        c_mon   = 1'b0;
        c_yr    = 1'b0;
        h24_inc = bcd_inc({2'b00, cur.hour[5:0]});
        h12     = {3'b000, cur.hour[4:0]};
        h12_inc = bcd_inc(h12);
        pm      = cur.hour[5];
        dim     = last_day(cur.month, cur.year);

        // seconds
        if (cur.sec >= 8'h59) begin
            nxt.sec = 8'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = bcd_inc(cur.sec);
        end

        // minutes
        if (c_min) begin
            if (cur.min >= 8'h59) begin
                nxt.min = 8'h00;
                c_hr    = 1'b1;
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end

        // hours
        if (c_hr) begin
            if (cur.hour[7]) begin
                if (cur.hour[5:0] >= 6'h23) begin
                    nxt.hour = 8'h80;
                    c_day    = 1'b1;
                end else begin
                    nxt.hour = {2'b10, h24_inc[5:0]};
                end
            end else begin
                if (h12 == 8'h11) begin
                    nxt.hour = {2'b00, ~pm, 5'h12};
                    c_day    = pm;
                end else if (h12 >= 8'h12) begin
                    nxt.hour = {2'b00, pm, 5'h01};
                end else begin
                    nxt.hour = {2'b00, pm, h12_inc[4:0]};
                end
            end
        end

        // date and day of week
        if (c_day) begin
            nxt.wday = (cur.wday >= 8'h06) ? 8'h00 : cur.wday + 8'h01;
            if (cur.date >= dim) begin
                nxt.date = 8'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.date = bcd_inc(cur.date);
            end
        end

        // month
        if (c_mon) begin
            if (cur.month >= 8'h12) begin
                nxt.month = 8'h01;
                c_yr      = 1'b1;
            end else begin
                nxt.month = bcd_inc(cur.month);
            end
        end

        // year and century
        if (c_yr) begin
            if (cur.year >= 8'h99) begin
                nxt.year = 8'h00;
                nxt.cent = CENT_HI;
            end else begin
                nxt.year = bcd_inc(cur.year);
            end
        end
    end

endmodule

// File: rtl/rtc_stage.sv
module rtc_stage
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rtc_time_t         live,
    input  logic              begin_i,
    input  logic              we,
    input  logic [IDX_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              commit,
    input  logic              abort,
    output rtc_time_t         buf_o,
    output logic              fire_o,
    output logic              wrote_o
);

    logic      active_q, wrote_q;
    rtc_time_t buf_q;
    logic [NUM_REGS*BYTE_W-1:0] buf_vec;

    always_comb begin
        buf_vec = buf_q;
        buf_vec[sel*BYTE_W +: BYTE_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wrote_q  <= 1'b0;
            buf_q    <= RESET_TIME;
        end else if (begin_i) begin
            active_q <= 1'b1;
            wrote_q  <= 1'b0;
            buf_q    <= live;
        end else if (active_q) begin
            if (commit || abort) begin
                active_q <= 1'b0;
            end else if (we) begin
                buf_q   <= rtc_time_t'(buf_vec);
                wrote_q <= 1'b1;
            end
        end
    end

    assign buf_o   = buf_q;
    assign fire_o  = commit && active_q && !begin_i;
    assign wrote_o = wrote_q;

    AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!begin_i && !(we && active_q)) |=> $stable(buf_q)); // R8

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !begin_i) |=> !wrote_q || $stable(wrote_q)); // R8

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snap,
    input  rtc_time_t         live,
    input  logic [IDX_W-1:0]  sel,
    output logic [BYTE_W-1:0] rd_data
);

    rtc_time_t shot_q;
    logic [NUM_REGS*BYTE_W-1:0] shot_vec;

    always_ff @(posedge clk) begin
        if (rst)       shot_q <= RESET_TIME;
        else if (snap) shot_q <= live;
    end

    assign shot_vec = shot_q;
    assign rd_data  = shot_vec[sel*BYTE_W +: BYTE_W];

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(shot_q)); // R7

endmodule

// File: rtl/bcd_rtc_shadow.sv
module bcd_rtc_shadow
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              snap_req,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              stg_begin,
    input  logic              stg_we,
    input  logic [IDX_W-1:0]  stg_sel,
    input  logic [BYTE_W-1:0] stg_wdata,
    input  logic              stg_commit,
    input  logic              stg_abort,
    output logic              halted
);

    rtc_time_t live_q, next_t, stage_t;
    logic      halted_q, fire, wrote;

    rtc_advance u_adv (
        .cur (live_q),
        .nxt (next_t)
    );

    rtc_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .live    (live_q),
        .begin_i (stg_begin),
        .we      (stg_we),
        .sel     (stg_sel),
        .wdata   (stg_wdata),
        .commit  (stg_commit),
        .abort   (stg_abort),
        .buf_o   (stage_t),
        .fire_o  (fire),
        .wrote_o (wrote)
    );

    rtc_snapshot u_snap (
        .clk     (clk),
        .rst     (rst),
        .snap    (snap_req),
        .live    (live_q),
        .sel     (rd_sel),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= RESET_TIME;
            halted_q <= 1'b1;
        end else if (fire) begin
            live_q <= stage_t;
            if (wrote) halted_q <= 1'b0;
        end else if (tick_1hz && !halted_q) begin
            live_q <= next_t;
        end
    end

    assign halted = halted_q;

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (halted_q && !fire) |=> $stable(live_q)); // R9

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !halted_q && !fire && live_q.sec == 8'h59)
        |=> (live_q.sec == 8'h00)); // R1

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !halted_q && !fire && live_q.wday <= 8'h06)
        |=> (live_q.wday <= 8'h06)); // R2

    AST_HOUR24_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !halted_q && !fire && live_q.hour[7] && live_q.hour[5:0] <= 6'h23)
        |=> (live_q.hour[7] && live_q.hour[5:0] <= 6'h23)); // R3

    AST_CENT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !halted_q && !fire && live_q.cent == CENT_HI)
        |=> (live_q.cent == CENT_HI)); // R6

endmodule

// File: tb/tb_bcd_rtc_shadow.sv
module tb_bcd_rtc_shadow;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0, snap_req = 1'b0;
    logic [2:0] rd_sel = '0, stg_sel = '0;
    logic [7:0] rd_data, stg_wdata = '0;
    logic       stg_begin = 1'b0, stg_we = 1'b0, stg_commit = 1'b0, stg_abort = 1'b0;
    logic       halted;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    bcd_rtc_shadow dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .snap_req(snap_req),
        .rd_sel(rd_sel), .rd_data(rd_data), .stg_begin(stg_begin), .stg_we(stg_we),
        .stg_sel(stg_sel), .stg_wdata(stg_wdata), .stg_commit(stg_commit),
        .stg_abort(stg_abort), .halted(halted)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic snap();
        @(negedge clk); snap_req = 1'b1;
        @(negedge clk); snap_req = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic stage_begin();
        @(negedge clk); stg_begin = 1'b1;
        @(negedge clk); stg_begin = 1'b0;
    endtask

    task automatic put(input logic [2:0] sel, input logic [7:0] v);
        @(negedge clk); stg_we = 1'b1; stg_sel = sel; stg_wdata = v;
        @(negedge clk); stg_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk); stg_commit = 1'b1;
        @(negedge clk); stg_commit = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, d, mo, y, w, c);
        stage_begin();
        put(0, s); put(1, mi); put(2, h); put(3, d);
        put(4, mo); put(5, y); put(6, w); put(7, c);
        commit();
    endtask

    task automatic expect_all(input string tag, input logic [7:0] s, mi, h, d, mo, y, w, c);
        logic [7:0] v;
        snap();
        rd(0, v); check({tag, " sec"}, v, s);
        rd(1, v); check({tag, " min"}, v, mi);
        rd(2, v); check({tag, " hour"}, v, h);
        rd(3, v); check({tag, " date"}, v, d);
        rd(4, v); check({tag, " month"}, v, mo);
        rd(5, v); check({tag, " year"}, v, y);
        rd(6, v); check({tag, " wday"}, v, w);
        rd(7, v); check({tag, " cent"}, v, c);
    endtask

    task automatic t_reset_halt();
        logic [7:0] v;
        check("R9 halted after reset", {7'd0, halted}, 8'h01);
        expect_all("R4 R6 reset", 8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
        pulse_tick(); pulse_tick();
        snap(); rd(0, v); check("R9 no advance while halted", v, 8'h00);
        stage_begin(); commit();
        check("R9 empty commit keeps halt", {7'd0, halted}, 8'h01);
        stage_begin(); put(0, 8'h05); commit();
        check("R9 halt cleared", {7'd0, halted}, 8'h00);
        expect_all("R8 single byte", 8'h05, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
        pulse_tick();
        snap(); rd(0, v); check("R1 sec step", v, 8'h06);
    endtask

    task automatic t_year_end();
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06, 8'h19);
        pulse_tick();
        expect_all("R11 R6 R3 R2 year end", 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h02, 8'h20);
        pulse_tick();
        expect_all("R6 century holds", 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h03, 8'h20);
    endtask

    task automatic t_minute_hour();
        set_time(8'h59, 8'h09, 8'h85, 8'h10, 8'h03, 8'h10, 8'h01, 8'h20);
        pulse_tick();
        expect_all("R1 min bcd", 8'h00, 8'h10, 8'h85, 8'h10, 8'h03, 8'h10, 8'h01, 8'h20);
        set_time(8'h59, 8'h59, 8'h89, 8'h10, 8'h03, 8'h10, 8'h01, 8'h20);
        pulse_tick();
        expect_all("R3 hour 09 to 10", 8'h00, 8'h00, 8'h90, 8'h10, 8'h03, 8'h10, 8'h01, 8'h20);
    endtask

    task automatic t_month_len();
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h03, 8'h20);
        pulse_tick();
        expect_all("R5 leap feb28", 8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h24, 8'h04, 8'h20);
        pulse_tick();
        set_time(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h04, 8'h20);
        pulse_tick();
        expect_all("R5 leap feb29", 8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h24, 8'h05, 8'h20);
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h02, 8'h20);
        pulse_tick();
        expect_all("R5 common feb28", 8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h23, 8'h03, 8'h20);
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h23, 8'h06, 8'h20);
        pulse_tick();
        expect_all("R5 R2 apr30", 8'h00, 8'h00, 8'h80, 8'h01, 8'h05, 8'h23, 8'h00, 8'h20);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h01, 8'h12, 8'h00, 8'h20);
        pulse_tick();
        expect_all("R5 jan31", 8'h00, 8'h00, 8'h80, 8'h01, 8'h02, 8'h12, 8'h01, 8'h20);
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h01, 8'h12, 8'h00, 8'h20);
        pulse_tick();
        expect_all("R5 jan30", 8'h00, 8'h00, 8'h80, 8'h31, 8'h01, 8'h12, 8'h01, 8'h20);
    endtask

    task automatic t_12h();
        set_time(8'h59, 8'h59, 8'h11, 8'h15, 8'h06, 8'h20, 8'h02, 8'h20);
        pulse_tick();
        expect_all("R4 11am to 12pm", 8'h00, 8'h00, 8'h32, 8'h15, 8'h06, 8'h20, 8'h02, 8'h20);
        set_time(8'h59, 8'h59, 8'h32, 8'h15, 8'h06, 8'h20, 8'h02, 8'h20);
        pulse_tick();
        expect_all("R4 12pm to 1pm", 8'h00, 8'h00, 8'h21, 8'h15, 8'h06, 8'h20, 8'h02, 8'h20);
        set_time(8'h59, 8'h59, 8'h31, 8'h15, 8'h06, 8'h20, 8'h02, 8'h20);
        pulse_tick();
        expect_all("R4 11pm to 12am", 8'h00, 8'h00, 8'h12, 8'h16, 8'h06, 8'h20, 8'h03, 8'h20);
    endtask

    task automatic t_snapshot();
        logic [7:0] v;
        set_time(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
        snap();
        pulse_tick(); pulse_tick(); pulse_tick();
        rd(0, v); check("R7 latch held", v, 8'h00);
        snap(); rd(0, v); check("R7 new snapshot", v, 8'h03);
    endtask

    task automatic t_staging();
        logic [7:0] v;
        set_time(8'h10, 8'h05, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
        stage_begin();
        pulse_tick(); pulse_tick();
        snap(); rd(0, v); check("R8 runs while staged", v, 8'h12);
        put(1, 8'h30);
        commit();
        snap();
        rd(0, v); check("R8 unwritten byte from begin", v, 8'h10);
        rd(1, v); check("R8 written byte", v, 8'h30);
        stage_begin(); put(0, 8'h45);
        @(negedge clk); stg_abort = 1'b1;
        @(negedge clk); stg_abort = 1'b0;
        pulse_tick();
        snap(); rd(0, v); check("R8 abort discards", v, 8'h11);
        put(0, 8'h33); commit();
        snap(); rd(0, v); check("R8 write without begin ignored", v, 8'h11);
        stage_begin(); put(0, 8'h20);
        @(negedge clk); stg_commit = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); stg_commit = 1'b0; tick_1hz = 1'b0;
        snap(); rd(0, v); check("R10 commit beats tick", v, 8'h20);
        pulse_tick();
        snap(); rd(0, v); check("R10 next tick from commit", v, 8'h21);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_halt();
        t_year_end();
        t_minute_hour();
        t_month_len();
        t_12h();
        t_snapshot();
        t_staging();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule